// File: doc/BRIEF.md
# GPIO Pin Interrupt and Wake Cell

This block is the logic behind a single 32-bit control and status word of a general-purpose I/O controller. It stores the pad direction and drive value, reports the filtered input level, and detects interrupt events on that input. Event detection works in edge mode (rising, falling or either edge) or in level mode (high or low). A captured event is held in a sticky status bit that software clears by writing 1.

Two separate controls shape the interrupt path. The enable bit decides whether an event is captured into status at all. The unmask bit decides whether captured status is forwarded as a pending request. A second sticky bit records wake events. Each wake event is qualified by one of three wake enables, and the present system sleep state selects which one applies. Pull and drive-strength settings are only held in the word and passed to the pad.

The controller writes the whole word in one cycle through a 32-bit write port, and reads it back on `rd_data_o`. The debouncer supplies the filtered pin level, and the power manager supplies the sleep state.

Top module: `gpio_pin_cell`

## Requirements
- R1: While rst_ni is low, every readable bit is 0 and every output is 0.
- R2: A write stores bits [14:0] of wr_data_i, and they read back from the next cycle. The layout is: bit 0 level mode; bits [2:1] active code; bit 3 interrupt enable; bit 4 unmask; bit 5 wake enable in S0i3; bit 6 wake enable in S3; bit 7 wake enable in S4/S5; bit 8 pull-up enable; bit 9 pull-up strength; bit 10 pull-down enable; bits [12:11] drive strength; bit 13 output enable; bit 14 output value. Bits [31:18] read 0. The pad and pull outputs mirror the stored bits.
- R3: Bit 15 is read-only and shows pin_i as sampled at the previous clock edge. Writes to bit 15 have no effect.
- R4: When bit 0 is 0 (edge mode), an event is a change of pin_i against its previous sample. Active code 00 selects rising edges, 01 selects falling edges and 10 selects both edges.
- R5: When bit 0 is 1 (level mode), code 00 gives an event on every cycle that pin_i is 1, and code 01 on every cycle that pin_i is 0. Status therefore sets again after a clear while the level persists. Code 10 in level mode and code 11 in either mode never give an event.
- R6: Interrupt status (bit 16) is set one cycle after an event only when interrupt enable is 1.
- R7: irq_pend_o is 1 exactly when bit 16 or bit 17 is set and the unmask bit is 1.
- R8: Writing 1 to bit 16 or bit 17 clears that bit, and writing 0 leaves it unchanged. An event in the same cycle as the clear wins.
- R9: Wake status (bit 17) is set on an event only when the wake enable for the current sleep_state_i is 1. The sleep codes are 0 running, 1 S0i3, 2 S3 and 3 S4/S5. In the running state no wake is recorded. Interrupt enable does not affect wake status.
- R10: wake_pend_o reflects bit 17 and does not depend on the unmask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Filtered pin level from the debouncer |
| sleep_state_i | input | 2 | Current sleep state code |
| wr_en_i | input | 1 | Word write strobe |
| wr_data_i | input | 32 | Word write data |
| rd_data_o | output | 32 | Readback of the control/status word |
| irq_pend_o | output | 1 | Forwarded pending request |
| wake_pend_o | output | 1 | Wake status to the power manager |
| pad_oe_o | output | 1 | Pad output enable |
| pad_out_o | output | 1 | Pad output value |
| pull_up_en_o | output | 1 | Pull-up enable |
| pull_up_sel_o | output | 1 | Pull-up strength select |
| pull_dn_en_o | output | 1 | Pull-down enable |
| drv_str_o | output | 2 | Drive-strength code |

## Verification
Configuration written in one cycle appears on the readback and the pad outputs after the next clock edge. The pin-status bit and both status bits also change one edge after the pin level that caused them was sampled. The pending outputs follow the status bits in the same cycle, without a register. The bench model advances on each rising edge from the inputs held since the previous edge. The bench compares every output against that model at the falling edge, so every result is checked in the cycle it is due.

// File: rtl/gpio_cell_pkg.sv
package gpio_cell_pkg;
  localparam int REG_W      = 32;
  localparam int PIN_STS_B  = 15;
  localparam int INT_STS_B  = 16;
  localparam int WAKE_STS_B = 17;
  localparam int NUM_STS    = 2;
  localparam int NUM_WAKE   = 3;

  typedef enum logic [1:0] {
    ACT_HI_RISE = 2'b00,
    ACT_LO_FALL = 2'b01,
    ACT_BOTH    = 2'b10,
    ACT_RSVD    = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    SLP_RUN  = 2'd0,
    SLP_IDLE = 2'd1,
    SLP_SUSP = 2'd2,
    SLP_OFF  = 2'd3
  } sleep_e;

  // packed MSB first: matches word bits [14:0]
  typedef struct packed {
    logic                out_val;
    logic                oe;
    logic [1:0]          drv;
    logic                pd_en;
    logic                pu_sel;
    logic                pu_en;
    logic [NUM_WAKE-1:0] wake_en;
    logic                unmask;
    logic                int_en;
    act_e                act;
    logic                lvl;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/gpio_cfg_reg.sv
module gpio_cfg_reg
  import gpio_cell_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] wr_cfg_i,
  output cfg_t             cfg_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cfg_q <= '0;
    else if (wr_en_i) cfg_q <= cfg_t'(wr_cfg_i);
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/gpio_evt_det.sv
module gpio_evt_det
  import gpio_cell_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic lvl_i,
  input  act_e act_i,
  output logic pin_q_o,
  output logic evt_o
);
  logic pin_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else         pin_q <= pin_i;
  end

  assign rise = pin_i & ~pin_q;
  assign fall = ~pin_i & pin_q;

  always_comb begin
    evt_o = 1'b0;
    if (lvl_i) begin
      unique case (act_i)
        ACT_HI_RISE: evt_o = pin_i;
        ACT_LO_FALL: evt_o = ~pin_i;
        default:     evt_o = 1'b0; // both-edge code invalid for levels
      endcase
    end else begin
      unique case (act_i)
        ACT_HI_RISE: evt_o = rise;
        ACT_LO_FALL: evt_o = fall;
        ACT_BOTH:    evt_o = rise | fall;
        default:     evt_o = 1'b0;
      endcase
    end
  end

  assign pin_q_o = pin_q;
endmodule

// File: rtl/gpio_sts_bit.sv
module gpio_sts_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic sts_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sts_o <= 1'b0;
    else if (set_i) sts_o <= 1'b1; // set wins over clear
    else if (clr_i) sts_o <= 1'b0;
  end
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_cell_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic [1:0]       sleep_state_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             irq_pend_o,
  output logic             wake_pend_o,
  output logic             pad_oe_o,
  output logic             pad_out_o,
  output logic             pull_up_en_o,
  output logic             pull_up_sel_o,
  output logic             pull_dn_en_o,
  output logic [1:0]       drv_str_o
);
  cfg_t               cfg;
  logic               pin_q;
  logic               evt;
  logic               wake_ok;
  logic [NUM_STS-1:0] sts_set, sts_clr, sts;

  gpio_cfg_reg u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_cfg_i (wr_data_i[CFG_W-1:0]),
    .cfg_o    (cfg)
  );

  gpio_evt_det u_det (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_i   (pin_i),
    .lvl_i   (cfg.lvl),
    .act_i   (cfg.act),
    .pin_q_o (pin_q),
    .evt_o   (evt)
  );

  always_comb begin
    unique case (sleep_e'(sleep_state_i))
      SLP_IDLE: wake_ok = cfg.wake_en[0];
      SLP_SUSP: wake_ok = cfg.wake_en[1];
      SLP_OFF:  wake_ok = cfg.wake_en[2];
      default:  wake_ok = 1'b0;
    endcase
  end

  assign sts_set[0] = evt & cfg.int_en;
  assign sts_set[1] = evt & wake_ok;

  for (genvar g = 0; g < NUM_STS; g++) begin : g_sts
    assign sts_clr[g] = wr_en_i & wr_data_i[INT_STS_B+g];
    gpio_sts_bit u_sts (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (sts_set[g]),
      .clr_i  (sts_clr[g]),
      .sts_o  (sts[g])
    );
  end

  always_comb begin
    rd_data_o                            = '0;
    rd_data_o[CFG_W-1:0]                 = cfg;
    rd_data_o[PIN_STS_B]                 = pin_q;
    rd_data_o[INT_STS_B+:NUM_STS]        = sts;
  end

  assign irq_pend_o    = (|sts) & cfg.unmask;
  assign wake_pend_o   = sts[1];
  assign pad_oe_o      = cfg.oe;
  assign pad_out_o     = cfg.out_val;
  assign pull_up_en_o  = cfg.pu_en;
  assign pull_up_sel_o = cfg.pu_sel;
  assign pull_dn_en_o  = cfg.pd_en;
  assign drv_str_o     = cfg.drv;
endmodule

// File: rtl/gpio_pin_cell_chk.sv
module gpio_pin_cell_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        pin_i,
  input logic [1:0]  sleep_state_i,
  input logic        wr_en_i,
  input logic [31:0] wr_data_i,
  input logic [31:0] rd_data_o,
  input logic        irq_pend_o,
  input logic        wake_pend_o
);
  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (rd_data_o == 32'd0 && !irq_pend_o));

  assert_cfg_store_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o[14:0] == $past(wr_data_i[14:0]));

  assert_pin_sample_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> rd_data_o[15] == $past(pin_i));

  assert_level_reset_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[0] && rd_data_o[2:1] == 2'b00 && rd_data_o[3] && pin_i && !wr_en_i)
      |=> rd_data_o[16]);

  assert_no_capture_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_data_o[3] && !rd_data_o[16]) |=> !rd_data_o[16]);

  assert_pend_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pend_o == ((rd_data_o[16] | rd_data_o[17]) & rd_data_o[4]));

  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[16] && !wr_en_i) |=> rd_data_o[16]);

  assert_no_wake_run_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_state_i == 2'd0 && !rd_data_o[17]) |=> !rd_data_o[17]);

  assert_wake_out_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_pend_o == rd_data_o[17]);
endmodule

bind gpio_pin_cell gpio_pin_cell_chk chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pin_i         (pin_i),
  .sleep_state_i (sleep_state_i),
  .wr_en_i       (wr_en_i),
  .wr_data_i     (wr_data_i),
  .rd_data_o     (rd_data_o),
  .irq_pend_o    (irq_pend_o),
  .wake_pend_o   (wake_pend_o)
);

// File: tb/gpio_pin_cell_tb_top.sv
`timescale 1ns/1ps
module gpio_pin_cell_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin = 1'b0;
  logic [1:0]  slp = 2'd0;
  logic        we = 1'b0;
  logic [31:0] wd = 32'd0;
  logic [31:0] rd;
  logic        irq, wk, oe, ov, pue, pus, pde;
  logic [1:0]  drv;

  always #4 clk = ~clk; // 125 MHz

  gpio_pin_cell dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .sleep_state_i(slp),
    .wr_en_i(we), .wr_data_i(wd), .rd_data_o(rd), .irq_pend_o(irq),
    .wake_pend_o(wk), .pad_oe_o(oe), .pad_out_o(ov), .pull_up_en_o(pue),
    .pull_up_sel_o(pus), .pull_dn_en_o(pde), .drv_str_o(drv)
  );

  // behavioural reference
  logic [14:0] m_cfg = '0;
  logic        m_pin = 1'b0, m_ist = 1'b0, m_wst = 1'b0;
  int          vectors = 0, errors = 0, cycles = 0;
  string       cur_req = "R1";
  bit          done = 0;

  function automatic bit ref_event(input logic [14:0] c, input logic p, input logic pp);
    int code;
    code = int'(c[2:1]);
    if (c[0]) return (code == 0) ? p : (code == 1) ? !p : 1'b0;
    if (code == 0) return p && !pp;
    if (code == 1) return !p && pp;
    if (code == 2) return p != pp;
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = '0; m_pin = 0; m_ist = 0; m_wst = 0;
    end else begin
      bit ev, wok;
      ev  = ref_event(m_cfg, pin, m_pin);
      wok = (slp == 2'd1) ? m_cfg[5] : (slp == 2'd2) ? m_cfg[6] : (slp == 2'd3) ? m_cfg[7] : 1'b0;
      if (ev && m_cfg[3]) m_ist = 1; else if (we && wd[16]) m_ist = 0;
      if (ev && wok)      m_wst = 1; else if (we && wd[17]) m_wst = 0;
      if (we) m_cfg = wd[14:0];
      m_pin = pin;
    end
  end

  task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      cmp("rd_data", rd, {14'd0, m_wst, m_ist, m_pin, m_cfg});
      cmp("irq_pend", {31'd0, irq}, {31'd0, (m_ist | m_wst) & m_cfg[4]});
      cmp("wake_pend", {31'd0, wk}, {31'd0, m_wst});
      cmp("pad", {28'd0, oe, ov, pue, pus}, {28'd0, m_cfg[13], m_cfg[14], m_cfg[8], m_cfg[9]});
      cmp("pull_dn_drv", {29'd0, pde, drv}, {29'd0, m_cfg[10], m_cfg[12:11]});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [31:0] d);
    we = 1; wd = d; cyc(1); we = 0; wd = 0;
  endtask

  function automatic logic [31:0] cfgv(input bit lvl, input bit [1:0] act,
                                       input bit ien, input bit um, input bit [2:0] wke);
    return {17'd0, 7'd0, wke, um, ien, act, lvl};
  endfunction

  initial begin
    cur_req = "R1"; cyc(3);
    rst_n = 1; cyc(1);

    cur_req = "R2";
    wr(32'hFFFF_7FFF); cyc(1);
    wr(32'h0000_5A96); cyc(1);
    wr(32'h0003_2B49); cyc(1);

    cur_req = "R3";
    wr(32'h0000_8000);
    pin = 1; cyc(2); pin = 0; cyc(1); pin = 1; cyc(1);
    wr(32'h0000_8000); pin = 0; cyc(2);

    cur_req = "R4";
    wr(cfgv(0, 2'b00, 1, 1, 3'b000) | 32'h3_0000);
    pin = 1; cyc(2); wr(cfgv(0, 2'b00, 1, 1, 0) | 32'h1_0000);
    pin = 0; cyc(2);
    wr(cfgv(0, 2'b01, 1, 1, 0)); pin = 1; cyc(2); pin = 0; cyc(2);
    wr(cfgv(0, 2'b01, 1, 1, 0) | 32'h1_0000);
    wr(cfgv(0, 2'b10, 1, 1, 0)); pin = 1; cyc(2);
    wr(cfgv(0, 2'b10, 1, 1, 0) | 32'h1_0000); pin = 0; cyc(2);
    wr(cfgv(0, 2'b11, 1, 1, 0) | 32'h1_0000); pin = 1; cyc(2); pin = 0; cyc(2);

    cur_req = "R5";
    wr(cfgv(1, 2'b00, 1, 1, 0)); pin = 1; cyc(3);
    wr(cfgv(1, 2'b00, 1, 1, 0) | 32'h1_0000); cyc(2);
    pin = 0; wr(cfgv(1, 2'b00, 1, 1, 0) | 32'h1_0000); cyc(2);
    wr(cfgv(1, 2'b01, 1, 1, 0)); cyc(2);
    pin = 1; wr(cfgv(1, 2'b01, 1, 1, 0) | 32'h1_0000); cyc(2);
    wr(cfgv(1, 2'b10, 1, 1, 0)); pin = 0; cyc(2); pin = 1; cyc(2);

    cur_req = "R6";
    wr(cfgv(0, 2'b10, 0, 1, 0) | 32'h3_0000); pin = 0; cyc(2); pin = 1; cyc(2);

    cur_req = "R7";
    wr(cfgv(0, 2'b00, 1, 0, 0)); pin = 0; cyc(1); pin = 1; cyc(2);
    wr(cfgv(0, 2'b00, 1, 1, 0)); cyc(1);

    cur_req = "R8";
    wr(cfgv(0, 2'b00, 1, 1, 0)); cyc(1);
    wr(cfgv(0, 2'b00, 1, 1, 0) | 32'h1_0000); pin = 0; cyc(1);
    pin = 1; wr(cfgv(0, 2'b00, 1, 1, 0) | 32'h1_0000); cyc(2);

    cur_req = "R9";
    for (int s = 0; s < 4; s++) begin
      for (int w = 0; w < 3; w++) begin
        slp = 2'(s);
        wr(cfgv(0, 2'b10, 0, 1, 3'(1 << w)) | 32'h3_0000);
        pin = ~pin; cyc(2);
      end
    end
    slp = 0;

    cur_req = "R10";
    slp = 2'd2;
    wr(cfgv(0, 2'b10, 0, 0, 3'b010) | 32'h3_0000); pin = ~pin; cyc(2);
    wr(cfgv(0, 2'b10, 0, 0, 3'b010) | 32'h2_0000); cyc(2);

    cur_req = "R1";
    pin = 1; wr(cfgv(1, 2'b00, 1, 1, 3'b111)); cyc(2);
    rst_n = 0; cyc(2);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule